// File: doc/BRIEF.md
# Double-Buffered Crosspoint Control Register

This block is the digital control plane of an 8x4 crosspoint switch matrix. It holds one state bit for each of the 32 nodes. Each bit sits in a two-stage store. The first stage is a shadow copy that a host writes one node at a time. The second stage is the live copy, and it drives the 32 switch-enable outputs. A host can stage a whole new routing in the shadow copy without disturbing traffic. It then commits the whole routing with a single strobe. It can also hold that strobe low so that each node write takes effect on its own.

The host port has a 2-bit X select, a 3-bit Y select, a data bit, an active-low select, a read/write line and two active-low strobes. All of these are sampled on the system clock. A read returns the live bit of the addressed node on a separate output that carries its own enable.

When the live copy changes, the block opens the nodes that must open first. It closes newly requested nodes only after a fixed gap of BBM_CYCLES clocks. An asynchronous active-low reset clears both stages, which opens every node.

Top module: `xpoint_ctrl`

## Requirements
- R1: The node index is Y*4 + X, with X on addrX[1:0] and Y on addrY[2:0]. Bit n of switchEn is node n. A data value of 1 closes a node (enable 1) and 0 opens it.
- R2: With csN=0 and rdWr=0, a low-then-high pulse on strobe1N loads dataIn into the addressed shadow bit. The address and data present in the cycle the high level returns are the ones loaded. While strobe2N stays high, switchEn does not change.
- R3: A low-then-high pulse on strobe2N copies all 32 shadow bits into the live stage at once. switchEn then shows the new routing.
- R4: While strobe2N is held low, the live stage follows the shadow stage, so a single node write reaches switchEn without a separate commit.
- R5: While strobe1N is held low during a qualified write, the addressed shadow bit follows dataIn on every clock.
- R6: With rstN=1, csN=0 and rdWr=1, dataOe is 1 and dataOut is the live bit of the addressed node. Otherwise dataOe is 0 and dataOut is 0.
- R7: When the live stage changes, switchEn shows (old AND new) for BBM_CYCLES clocks, then shows the new value. No clock edge both sets and clears switchEn bits.
- R8: rstN low clears the shadow and live stages at once, with no clock edge, whatever the other inputs are. switchEn becomes 0.
- R9: With csN=1, strobe1N pulses leave the shadow stage unchanged and dataOe stays 0. strobe2N commits still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all host inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| csN | input | 1 | Host select, active low |
| rdWr | input | 1 | 1 = read live bit, 0 = write shadow bit |
| strobe1N | input | 1 | Shadow-stage load strobe, active low |
| strobe2N | input | 1 | Live-stage commit strobe, active low |
| addrX | input | 2 | X line select |
| addrY | input | 3 | Y line select |
| dataIn | input | 1 | Write data, 1 = close |
| dataOut | output | 1 | Read data, live state of the addressed node |
| dataOe | output | 1 | High while dataOut is driven by a qualified read |
| switchEn | output | 32 | Live switch enables, bit Y*4+X |

## Verification
The checker verifies a set of properties on every clock:
- readback always matches the live stage at the presented address;
- a deselected port never drives data;
- switchEn never sets and clears bits on the same edge;
- switchEn never enables a node that the live stage has open;
- reset holds both stages at zero.

Other behaviours can only be shown by the bench's scenarios:
- the exact length of the break-before-make gap;
- that shadow-only writes leave the outputs alone;
- the transparent modes of both strobes;
- that select gates strobe 1 but not strobe 2.

// File: rtl/xpoint_pkg.sv
package xpoint_pkg;
  // Per-cycle commands from the sequencer to the node store
  typedef struct packed {
    logic shadowWr;  // write dataIn into the addressed shadow bit
    logic liveLoad;  // copy the shadow stage into the live stage and open the gap
    logic gapHold;   // keep makes suppressed this cycle
  } xpCtrl_t;
endpackage

// File: rtl/xpoint_ctrl_seq.sv
module xpoint_ctrl_seq
  import xpoint_pkg::*;
#(
  parameter int BBM_CYCLES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    rdWr,
  input  logic    strobe1N,
  input  logic    strobe2N,
  input  logic    liveDiff,
  output xpCtrl_t ctl
);
  localparam int CNT_W = $clog2(BBM_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(BBM_CYCLES);
  localparam logic [CNT_W-1:0] GAP_ONE  = CNT_W'(1);

  logic s1Q;
  logic s2Q;
  logic [CNT_W-1:0] gapCnt;
  logic wrSel;
  logic s1Active;
  logic xferActive;

  // Strobe history: a low level now or in the previous cycle keeps the stage open,
  // so the rising edge that ends a pulse still performs one final load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Q    <= 1'b1;
      s2Q    <= 1'b1;
      gapCnt <= '0;
    end else begin
      s1Q <= strobe1N;
      s2Q <= strobe2N;
      if (ctl.liveLoad) begin
        gapCnt <= GAP_LOAD;
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - GAP_ONE;
      end
    end
  end

  always_comb begin
    wrSel        = !csN && !rdWr;
    s1Active     = !strobe1N || !s1Q;
    xferActive   = !strobe2N || !s2Q;
    ctl.shadowWr = wrSel && s1Active;
    ctl.liveLoad = xferActive && liveDiff;
    ctl.gapHold  = (gapCnt > GAP_ONE) && !ctl.liveLoad;
  end
endmodule

// File: rtl/xpoint_ctrl_store.sv
module xpoint_ctrl_store
  import xpoint_pkg::*;
#(
  parameter int X_BITS = 2,
  parameter int Y_BITS = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  xpCtrl_t                             ctl,
  input  logic                                csN,
  input  logic                                rdWr,
  input  logic [X_BITS-1:0]                   addrX,
  input  logic [Y_BITS-1:0]                   addrY,
  input  logic                                dataIn,
  output logic                                liveDiff,
  output logic [(1<<(X_BITS+Y_BITS))-1:0]     liveState,
  output logic [(1<<(X_BITS+Y_BITS))-1:0]     switchEn,
  output logic                                dataOut,
  output logic                                dataOe
);
  localparam int SEL_W = X_BITS + Y_BITS;
  localparam int NODES = 1 << SEL_W;

  logic [SEL_W-1:0] nodeSel;
  logic [NODES-1:0] wrMask;
  logic [NODES-1:0] shadowQ;
  logic [NODES-1:0] shadowNext;
  logic [NODES-1:0] liveQ;
  logic [NODES-1:0] enQ;

  assign nodeSel = {addrY, addrX};

  // One-hot write decode, one term per node
  for (genvar n = 0; n < NODES; n++) begin : g_dec
    assign wrMask[n] = ctl.shadowWr && (nodeSel == SEL_W'(n));
  end

  assign shadowNext = (shadowQ & ~wrMask) | (wrMask & {NODES{dataIn}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      liveQ   <= '0;
      enQ     <= '0;
    end else begin
      shadowQ <= shadowNext;
      if (ctl.liveLoad) begin
        liveQ <= shadowQ;
        enQ   <= enQ & shadowQ;      // breaks now, makes deferred
      end else if (ctl.gapHold) begin
        enQ   <= enQ & liveQ;
      end else begin
        enQ   <= liveQ;
      end
    end
  end

  assign liveDiff  = (shadowQ != liveQ);
  assign liveState = liveQ;
  assign switchEn  = enQ;
  assign dataOe    = rstN && !csN && rdWr;
  assign dataOut   = dataOe && liveQ[nodeSel];
endmodule

// File: rtl/xpoint_ctrl.sv
module xpoint_ctrl
  import xpoint_pkg::*;
#(
  parameter int X_BITS     = 2,
  parameter int Y_BITS     = 3,
  parameter int BBM_CYCLES = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            csN,
  input  logic                            rdWr,
  input  logic                            strobe1N,
  input  logic                            strobe2N,
  input  logic [X_BITS-1:0]               addrX,
  input  logic [Y_BITS-1:0]               addrY,
  input  logic                            dataIn,
  output logic                            dataOut,
  output logic                            dataOe,
  output logic [(1<<(X_BITS+Y_BITS))-1:0] switchEn
);
  localparam int NODES = 1 << (X_BITS + Y_BITS);

  xpCtrl_t          ctl;
  logic             liveDiff;
  logic [NODES-1:0] liveState;

  xpoint_ctrl_seq #(.BBM_CYCLES(BBM_CYCLES)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .rdWr     (rdWr),
    .strobe1N (strobe1N),
    .strobe2N (strobe2N),
    .liveDiff (liveDiff),
    .ctl      (ctl)
  );

  xpoint_ctrl_store #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .csN       (csN),
    .rdWr      (rdWr),
    .addrX     (addrX),
    .addrY     (addrY),
    .dataIn    (dataIn),
    .liveDiff  (liveDiff),
    .liveState (liveState),
    .switchEn  (switchEn),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );
endmodule

// File: rtl/xpoint_ctrl_chk.sv
module xpoint_ctrl_chk #(
  parameter int X_BITS = 2,
  parameter int Y_BITS = 3
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            csN,
  input logic [X_BITS-1:0]               addrX,
  input logic [Y_BITS-1:0]               addrY,
  input logic                            dataOut,
  input logic                            dataOe,
  input logic [(1<<(X_BITS+Y_BITS))-1:0] switchEn,
  input logic [(1<<(X_BITS+Y_BITS))-1:0] liveState
);
  // R6
  read_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dataOut == liveState[{addrY, addrX}]));

  // R9
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!dataOe && !dataOut));

  // R7
  bbm_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((switchEn & ~$past(switchEn)) != '0) |-> (($past(switchEn) & ~switchEn) == '0));

  // R7
  make_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((switchEn & ~liveState) == '0));

  // R8
  always @(posedge clk) begin
    if (!rstN) begin
      reset_clear_chk: assert (switchEn == '0 && liveState == '0);
    end
  end
endmodule

bind xpoint_ctrl xpoint_ctrl_chk #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .addrX     (addrX),
  .addrY     (addrY),
  .dataOut   (dataOut),
  .dataOe    (dataOe),
  .switchEn  (switchEn),
  .liveState (liveState)
);

// File: tb/xpoint_ctrl_tb_top.sv
`timescale 1ns/1ps
module xpoint_ctrl_tb_top;
  localparam int BBM = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        csN = 1'b1;
  logic        rdWr = 1'b0;
  logic        strobe1N = 1'b1;
  logic        strobe2N = 1'b1;
  logic [1:0]  addrX = '0;
  logic [2:0]  addrY = '0;
  logic        dataIn = 1'b0;
  logic        dataOut;
  logic        dataOe;
  logic [31:0] switchEn;

  int checks = 0;
  int errors = 0;
  bit doneF = 1'b0;

  logic [31:0] shadowM = '0;
  logic [31:0] liveM = '0;

  typedef struct {
    string       req;
    logic [33:0] expObs;
  } item_t;
  item_t q[$];
  event chkEv;

  always #10 clk = ~clk;

  xpoint_ctrl #(.BBM_CYCLES(BBM)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr),
    .strobe1N(strobe1N), .strobe2N(strobe2N),
    .addrX(addrX), .addrY(addrY), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .switchEn(switchEn)
  );

  // Monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chkEv);
      while (q.size() > 0) begin
        item_t it;
        logic [33:0] obs;
        it = q.pop_front();
        obs = {dataOe, dataOut, switchEn};
        checks++;
        if (obs !== it.expObs) begin
          errors++;
          $display("FAIL %s actual oe=%b out=%b sw=%h expected oe=%b out=%b sw=%h",
                   it.req, obs[33], obs[32], obs[31:0],
                   it.expObs[33], it.expObs[32], it.expObs[31:0]);
        end
      end
    end
  end

  task automatic expectNow(string req, logic [31:0] sw, logic oe, logic dout);
    item_t it;
    it.req = req;
    it.expObs = {oe, dout, sw};
    q.push_back(it);
    ->chkEv;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeNode(int x, int y, bit d, bit sel);
    addrX = 2'(x); addrY = 3'(y); dataIn = d;
    rdWr = 1'b0; csN = !sel; strobe1N = 1'b0;
    tick();
    strobe1N = 1'b1;
    tick();
    csN = 1'b1;
    if (sel) shadowM[y*4 + x] = d;
  endtask

  task automatic pulse2();
    strobe2N = 1'b0;
    tick();
    strobe2N = 1'b1;
    tick();
    liveM = shadowM;
    repeat (BBM) tick();
  endtask

  task automatic readNode(int x, int y, string req);
    addrX = 2'(x); addrY = 3'(y); csN = 1'b0; rdWr = 1'b1;
    #1;
    expectNow(req, liveM, 1'b1, liveM[y*4 + x]);
    csN = 1'b1; rdWr = 1'b0;
  endtask

  initial begin
    #(2_000_000);
    if (!doneF) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    expectNow("R8 reset state", 32'h0, 1'b0, 1'b0);

    // R2: shadow write alone, node (x1,y2) -> bit 9 (R1)
    writeNode(1, 2, 1'b1, 1'b1);
    expectNow("R2 shadow write leaves outputs", 32'h0, 1'b0, 1'b0);
    repeat (5) tick();
    expectNow("R2 still unchanged later", 32'h0, 1'b0, 1'b0);

    // R3: commit several nodes at once
    writeNode(3, 7, 1'b1, 1'b1);
    writeNode(0, 0, 1'b1, 1'b1);
    pulse2();
    expectNow("R3 commit all nodes", 32'h8000_0201, 1'b0, 1'b0);

    // R1 / R6 readback
    readNode(1, 2, "R1 read node index y*4+x closed");
    readNode(2, 2, "R6 read open node");
    addrX = 2'd1; addrY = 3'd2; csN = 1'b1; rdWr = 1'b1;
    #1;
    expectNow("R6 no drive when deselected", liveM, 1'b0, 1'b0);
    rdWr = 1'b0;

    // R7: open node 9, close node 5 in one commit
    writeNode(1, 2, 1'b0, 1'b1);
    writeNode(1, 1, 1'b1, 1'b1);
    strobe2N = 1'b0;
    tick();
    expectNow("R7 gap start old AND new", 32'h8000_0001, 1'b0, 1'b0);
    strobe2N = 1'b1;
    tick();
    tick();
    expectNow("R7 gap last cycle", 32'h8000_0001, 1'b0, 1'b0);
    tick();
    liveM = shadowM;
    expectNow("R7 new state after gap", 32'h8000_0021, 1'b0, 1'b0);

    // R9: deselected strobe1 ignored, strobe2 still commits
    writeNode(2, 3, 1'b1, 1'b0);
    pulse2();
    expectNow("R9 deselected write ignored", liveM, 1'b0, 1'b0);
    readNode(2, 3, "R9 ignored node reads open");
    writeNode(2, 3, 1'b1, 1'b1);
    csN = 1'b1;
    pulse2();
    expectNow("R9 commit with csN high", 32'h8000_4021, 1'b0, 1'b0);

    // R4: strobe2 held low, single write reaches outputs
    strobe2N = 1'b0;
    writeNode(3, 0, 1'b1, 1'b1);
    repeat (BBM + 1) tick();
    liveM = shadowM;
    expectNow("R4 transparent live stage", 32'h8000_4029, 1'b0, 1'b0);

    // R5: strobe1 held low, shadow follows dataIn (node 16)
    addrX = 2'd0; addrY = 3'd4; csN = 1'b0; rdWr = 1'b0; dataIn = 1'b1;
    strobe1N = 1'b0;
    repeat (BBM + 3) tick();
    expectNow("R5 transparent shadow close", 32'h8001_4029, 1'b0, 1'b0);
    dataIn = 1'b0;
    repeat (BBM + 3) tick();
    expectNow("R5 transparent shadow open", 32'h8000_4029, 1'b0, 1'b0);
    strobe1N = 1'b1;
    tick();
    csN = 1'b1; strobe2N = 1'b1;
    tick();
    tick();

    // R8: asynchronous reset with the port deselected
    rstN = 1'b0;
    #2;
    expectNow("R8 async clear", 32'h0, 1'b0, 1'b0);
    tick();
    rstN = 1'b1;
    shadowM = '0; liveM = '0;
    tick();
    readNode(3, 7, "R8 node reads open after reset");
    pulse2();
    expectNow("R8 shadow cleared too", 32'h0, 1'b0, 1'b0);

    doneF = 1'b1;
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule